// File: doc/BRIEF.md
# Programmable Chip Select Unit

This block turns the bus address into a set of active-low select lines, one per memory or peripheral region. Every select has its own base address, address mask, port width (8 or 16 bits) and valid bit, all set through a simple write port. The decode uses 8 KB blocks: the low 13 address bits never take part in a match. A select output goes low only while address strobe is asserted. The port width of the select that fired goes to the bus sizing logic.

Select 0 is the boot select. It comes out of reset already live over the lowest 8 KB, so the processor can fetch its reset vectors before any software has run. Its port width after reset comes from a strap pin. Every other select stays silent after reset until software writes a valid base and mask. A configuration write is staged and only reaches the decoder at a clock edge where address strobe is negated. A bus cycle in progress never sees its decode change. When regions overlap, the lowest-numbered select wins.

Top module: `cs_unit`

## Requirements
- R1: All select outputs are active-low; while `as_ni` is high every bit of `cs_no` is 1, in the same cycle that the strobe is negated.
- R2: After reset, with no write to select 0, `cs_no[0]` is 0 for every strobed address below 0x002000 and 1 for every address at or above it.
- R3: After reset the boot select's width follows `boot_wide_strap_i`: `wide_o` is 0 (8-bit port) when the strap is 0 and 1 (16-bit port) when the strap is 1.
- R4: Selects 1 and above never assert after reset until a write with `cfg_valid_i`=1 has been made to them.
- R5: Select i matches when (address AND mask) equals (base AND mask), computed on address bits 23..13 only; bits 12..0 of address, base and mask are ignored.
- R6: `wide_o` is the programmed width of the asserted select (1 = 16-bit, 0 = 8-bit), and is 0 when no select asserts.
- R7: When several selects match, only the lowest-numbered one asserts; at most one bit of `cs_no` is 0 at any time.
- R8: A write to a select takes effect at the first clock edge after the write at which `as_ni` is high; while the strobe stays low the decode seen on the bus does not change.
- R9: Any select, including the boot select, can be moved to a new base, and a write with `cfg_valid_i`=0 disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | Bus address |
| as_ni | input | 1 | Address strobe, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 2 | Index of the select being written |
| cfg_base_i | input | 24 | Base address (bits 12..0 ignored) |
| cfg_mask_i | input | 24 | Address mask (bits 12..0 ignored) |
| cfg_wide_i | input | 1 | Port width: 1 = 16-bit, 0 = 8-bit |
| cfg_valid_i | input | 1 | Enable for the select |
| boot_wide_strap_i | input | 1 | Boot select width strap |
| cs_no | output | 4 | Select outputs, active low |
| wide_o | output | 1 | Width of the asserted select |

## Verification
The bound checker watches several rules on every cycle. Selects stay idle while the strobe is high. At most one select asserts. A select that has never been enabled stays quiet. The boot region decodes until select 0 is written. The outputs do not move inside a strobed cycle with a steady address, and the width output is zero when nothing is selected. Only the bench's scenarios can show the match arithmetic against chosen bases and masks, that the low address bits are ignored, how overlapping regions resolve, that the strap sets the width, and how relocation and disabling work. The bench checks these against a behavioural model on every clock.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned BLK_W = 13;  // 8 KB decode granularity
  typedef enum logic {PORT8 = 1'b0, PORT16 = 1'b1} port_w_e;
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned TAG_W  = 11,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          as_ni,
  input  logic                          wr_en_i,
  input  logic [SEL_W-1:0]              wr_sel_i,
  input  logic [TAG_W-1:0]              wr_base_i,
  input  logic [TAG_W-1:0]              wr_mask_i,
  input  logic                          wr_wide_i,
  input  logic                          wr_valid_i,
  input  logic                          strap_i,
  output logic [NUM_CS-1:0][TAG_W-1:0]  base_o,
  output logic [NUM_CS-1:0][TAG_W-1:0]  mask_o,
  output logic [NUM_CS-1:0]             wide_o,
  output logic [NUM_CS-1:0]             valid_o
);
  logic strap_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strap_done_q <= 1'b0;
    else         strap_done_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    localparam logic             RST_VALID = (g == 0);
    localparam logic [TAG_W-1:0] RST_MASK  = (g == 0) ? {TAG_W{1'b1}} : '0;
    localparam logic             IS_BOOT   = (g == 0);

    logic [TAG_W-1:0] pend_base_q, pend_mask_q, act_base_q, act_mask_q;
    logic             pend_wide_q, pend_valid_q, act_wide_q, act_valid_q;
    logic             wr_hit, strap_load;

    assign wr_hit     = wr_en_i && (wr_sel_i == SEL_W'(g));
    assign strap_load = IS_BOOT && !strap_done_q;

    // staged copy written by software
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_base_q  <= '0;
        pend_mask_q  <= RST_MASK;
        pend_wide_q  <= 1'b0;
        pend_valid_q <= RST_VALID;
      end else if (wr_hit) begin
        pend_base_q  <= wr_base_i;
        pend_mask_q  <= wr_mask_i;
        pend_wide_q  <= wr_wide_i;
        pend_valid_q <= wr_valid_i;
      end else if (strap_load) begin
        pend_wide_q  <= strap_i;
      end
    end

    // live copy, only refreshed between bus cycles
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_base_q  <= '0;
        act_mask_q  <= RST_MASK;
        act_wide_q  <= 1'b0;
        act_valid_q <= RST_VALID;
      end else begin
        if (as_ni) begin
          act_base_q  <= pend_base_q;
          act_mask_q  <= pend_mask_q;
          act_valid_q <= pend_valid_q;
        end
        if (strap_load)  act_wide_q <= strap_i;
        else if (as_ni)  act_wide_q <= pend_wide_q;
      end
    end

    assign base_o[g]  = act_base_q;
    assign mask_o[g]  = act_mask_q;
    assign valid_o[g] = act_valid_q;
    assign wide_o[g]  = strap_load ? strap_i : act_wide_q;
  end
endmodule

// File: rtl/cs_match.sv
module cs_match #(
  parameter int unsigned TAG_W = 11
) (
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] base_i,
  input  logic [TAG_W-1:0] mask_i,
  input  logic             valid_i,
  output logic             hit_o
);
  assign hit_o = valid_i && (((tag_i ^ base_i) & mask_i) == '0);
endmodule

// File: rtl/cs_prio.sv
module cs_prio #(
  parameter int unsigned NUM_CS = 4
) (
  input  logic [NUM_CS-1:0] hit_i,
  output logic [NUM_CS-1:0] grant_o
);
  always_comb begin
    logic taken;
    taken   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      grant_o[i] = hit_i[i] && !taken;
      taken      = taken || hit_i[i];
    end
  end
endmodule

// File: rtl/cs_unit.sv
module cs_unit #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned SEL_W = $clog2(NUM_CS),
  localparam int unsigned TAG_W = ADDR_W - cs_pkg::BLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              as_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_mask_i,
  input  logic              cfg_wide_i,
  input  logic              cfg_valid_i,
  input  logic              boot_wide_strap_i,
  output logic [NUM_CS-1:0] cs_no,
  output logic              wide_o
);
  import cs_pkg::*;

  logic [NUM_CS-1:0][TAG_W-1:0] base, mask;
  logic [NUM_CS-1:0]            wide, valid, hit, grant;
  logic [TAG_W-1:0]             tag;

  assign tag = addr_i[ADDR_W-1:BLK_W];

  cs_cfg_regs #(.NUM_CS(NUM_CS), .TAG_W(TAG_W), .SEL_W(SEL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .as_ni      (as_ni),
    .wr_en_i    (cfg_we_i),
    .wr_sel_i   (cfg_sel_i),
    .wr_base_i  (cfg_base_i[ADDR_W-1:BLK_W]),
    .wr_mask_i  (cfg_mask_i[ADDR_W-1:BLK_W]),
    .wr_wide_i  (cfg_wide_i),
    .wr_valid_i (cfg_valid_i),
    .strap_i    (boot_wide_strap_i),
    .base_o     (base),
    .mask_o     (mask),
    .wide_o     (wide),
    .valid_o    (valid)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_match
    cs_match #(.TAG_W(TAG_W)) u_match (
      .tag_i   (tag),
      .base_i  (base[g]),
      .mask_i  (mask[g]),
      .valid_i (valid[g]),
      .hit_o   (hit[g])
    );
  end

  cs_prio #(.NUM_CS(NUM_CS)) u_prio (
    .hit_i   (hit),
    .grant_o (grant)
  );

  assign cs_no  = ~(grant & {NUM_CS{~as_ni}});
  assign wide_o = ~as_ni && (|(grant & wide));
endmodule

// File: rtl/cs_unit_chk.sv
module cs_unit_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned SEL_W = $clog2(NUM_CS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              as_ni,
  input logic              cfg_we_i,
  input logic [SEL_W-1:0]  cfg_sel_i,
  input logic              cfg_valid_i,
  input logic              boot_wide_strap_i,
  input logic [NUM_CS-1:0] cs_no,
  input logic              wide_o
);
  logic [NUM_CS-1:0] enabled_q;
  logic              boot_touched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enabled_q      <= '0;
      boot_touched_q <= 1'b0;
    end else if (cfg_we_i) begin
      if (cfg_valid_i) enabled_q[cfg_sel_i] <= 1'b1;
      if (cfg_sel_i == '0) boot_touched_q <= 1'b1;
    end
  end

  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |-> (&cs_no));

  a_r7_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  a_r6_no_width_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_no) |-> !wide_o);

  a_r2_boot_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_touched_q && !as_ni && (addr_i[ADDR_W-1:cs_pkg::BLK_W] == '0)) |-> !cs_no[0]);

  a_r8_steady_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_ni && $past(!as_ni) && $stable(addr_i) && $stable(boot_wide_strap_i))
      |-> ($stable(cs_no) && $stable(wide_o)));

  for (genvar g = 1; g < NUM_CS; g++) begin : g_quiet
    a_r4_quiet_until_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enabled_q[g] |-> cs_no[g]);
  end
endmodule

bind cs_unit cs_unit_chk #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .addr_i            (addr_i),
  .as_ni             (as_ni),
  .cfg_we_i          (cfg_we_i),
  .cfg_sel_i         (cfg_sel_i),
  .cfg_valid_i       (cfg_valid_i),
  .boot_wide_strap_i (boot_wide_strap_i),
  .cs_no             (cs_no),
  .wide_o            (wide_o)
);

// File: tb/cs_unit_test.sv
module cs_unit_test;
  localparam int AW = 24;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          as_n = 1'b1;
  logic          we = 1'b0;
  logic [1:0]    sel = '0;
  logic [AW-1:0] base = '0, mask = '0;
  logic          wide = 1'b0, valid = 1'b0;
  logic          strap = 1'b0;
  logic [NC-1:0] cs_n;
  logic          wide_out;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  cs_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .as_ni(as_n),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_base_i(base), .cfg_mask_i(mask),
    .cfg_wide_i(wide), .cfg_valid_i(valid), .boot_wide_strap_i(strap),
    .cs_no(cs_n), .wide_o(wide_out)
  );

  // reference model: staged and live settings per select
  int p_base[NC] = '{default: 0}, p_mask[NC] = '{default: 0};
  int p_wide[NC] = '{default: 0}, p_val[NC] = '{default: 0};
  int a_base[NC] = '{default: 0}, a_mask[NC] = '{default: 0};
  int a_wide[NC] = '{default: 0}, a_val[NC] = '{default: 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin
        p_base[i] = 0; p_mask[i] = (i == 0) ? 32'hFFFFFF : 0;
        p_wide[i] = (i == 0) ? int'(strap) : 0; p_val[i] = (i == 0) ? 1 : 0;
        a_base[i] = p_base[i]; a_mask[i] = p_mask[i];
        a_wide[i] = p_wide[i]; a_val[i] = p_val[i];
      end
    end else begin
      if (as_n) begin
        for (int i = 0; i < NC; i++) begin
          a_base[i] = p_base[i]; a_mask[i] = p_mask[i];
          a_wide[i] = p_wide[i]; a_val[i] = p_val[i];
        end
      end
      if (we) begin
        p_base[sel] = int'(base); p_mask[sel] = int'(mask);
        p_wide[sel] = int'(wide); p_val[sel] = int'(valid);
      end
    end
  end

  function automatic void model_out(output logic [NC-1:0] ecs, output logic ew);
    ecs = '1; ew = 1'b0;
    if (!as_n) begin
      for (int i = 0; i < NC; i++) begin
        if (a_val[i] != 0 &&
            (((int'(addr) >> 13) & (a_mask[i] >> 13)) == ((a_base[i] >> 13) & (a_mask[i] >> 13)))) begin
          ecs[i] = 1'b0; ew = a_wide[i][0];
          break;
        end
      end
    end
  endfunction

  always @(negedge clk) begin
    logic [NC-1:0] ecs;
    logic ew;
    #5;
    model_out(ecs, ew);
    checks++;
    if (cs_n !== ecs || wide_out !== ew) begin
      failures++;
      $display("FAIL %s model: cs=%b/%b wide=%b/%b", cur_req, cs_n, ecs, wide_out, ew);
    end
  end

  task automatic chk(input string req, input logic [NC-1:0] ecs, input logic ew);
    #5;
    checks++;
    if (cs_n !== ecs || wide_out !== ew) begin
      failures++;
      $display("FAIL %s: cs=%b exp %b wide=%b exp %b", req, cs_n, ecs, wide_out, ew);
    end
  endtask

  task automatic bus(input logic [AW-1:0] a, input logic asn);
    @(negedge clk);
    we = 1'b0; addr = a; as_n = asn;
  endtask

  task automatic wr(input int s, input logic [AW-1:0] b, input logic [AW-1:0] m,
                    input logic w, input logic v, input logic asn);
    @(negedge clk);
    we = 1'b1; sel = 2'(s); base = b; mask = m; wide = w; valid = v; as_n = asn;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; as_n = 1'b1; we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    cur_req = "R1"; bus(24'h000100, 1'b1); chk("R1", 4'hF, 1'b0);
    cur_req = "R2"; bus(24'h000100, 1'b0); chk("R3", 4'hE, 1'b0);
    bus(24'h001FFF, 1'b0); chk("R2", 4'hE, 1'b0);
    bus(24'h002000, 1'b0); chk("R2", 4'hF, 1'b0);
    cur_req = "R4"; bus(24'h400000, 1'b0); chk("R4", 4'hF, 1'b0);
    bus(24'h000010, 1'b1); chk("R1", 4'hF, 1'b0);

    do_reset(1'b1);
    cur_req = "R3"; bus(24'h000010, 1'b0); chk("R3", 4'hE, 1'b1);
    bus(24'h000010, 1'b1);

    cur_req = "R5";
    wr(1, 24'h100000, 24'hFF0000, 1'b1, 1'b1, 1'b1); bus(0, 1'b1);
    bus(24'h10ABCD, 1'b0); chk("R5", 4'hD, 1'b1);
    bus(24'h110000, 1'b0); chk("R5", 4'hF, 1'b0);
    bus(0, 1'b1);
    wr(2, 24'h200123, 24'hFFE0FF, 1'b0, 1'b1, 1'b1); bus(0, 1'b1);
    bus(24'h201FFF, 1'b0); chk("R5", 4'hB, 1'b0);
    bus(24'h202000, 1'b0); chk("R6", 4'hF, 1'b0);
    bus(0, 1'b1);

    cur_req = "R7";
    wr(3, 24'h100000, 24'hF00000, 1'b0, 1'b1, 1'b1); bus(0, 1'b1);
    bus(24'h10ABCD, 1'b0); chk("R7", 4'hD, 1'b1);
    bus(24'h180000, 1'b0); chk("R7", 4'h7, 1'b0);
    bus(0, 1'b1);

    cur_req = "R8";
    bus(24'h300000, 1'b0); chk("R8", 4'hF, 1'b0);
    wr(1, 24'h300000, 24'hFF0000, 1'b1, 1'b1, 1'b0); chk("R8", 4'hF, 1'b0);
    bus(24'h300000, 1'b0); chk("R8", 4'hF, 1'b0);
    bus(24'h300000, 1'b0); chk("R8", 4'hF, 1'b0);
    bus(24'h300000, 1'b1); chk("R1", 4'hF, 1'b0);
    bus(24'h300000, 1'b0); chk("R8", 4'hD, 1'b1);
    bus(0, 1'b1);

    cur_req = "R9";
    wr(0, 24'h800000, 24'hFFE000, 1'b1, 1'b1, 1'b1); bus(0, 1'b1);
    bus(24'h000100, 1'b0); chk("R9", 4'hF, 1'b0);
    bus(24'h800010, 1'b0); chk("R9", 4'hE, 1'b1);
    bus(0, 1'b1);
    wr(1, 24'h300000, 24'hFF0000, 1'b1, 1'b0, 1'b1); bus(0, 1'b1);
    bus(24'h300000, 1'b0); chk("R9", 4'hF, 1'b0);
    bus(0, 1'b1);
    bus(0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule